// File: doc/BRIEF.md
# Multi-Standard Frame Pulse Aligner

This block recovers the 8 kHz frame boundary from an active-low frame pulse and states it as a one-cycle strobe in the 16.384 MHz master-clock domain. The pulse can follow one of three timing conventions. In the single-cycle convention the pulse is low for one master clock (about 61 ns). When paired with an 8.192 MHz reference it is low for two master clocks (about 122 ns). When paired with a 4.096 MHz reference it is low for four master clocks (about 244 ns). A two-bit mode input tells the block which convention applies. All three convention clocks divide evenly from the master clock, so the block samples everything on the master clock. It uses the expected low width to tell the conventions apart.

From the recovered boundary, a frame-phase counter of 2048 master cycles drives two local timing outputs. The first is a clock at one quarter of the master rate (about 4.096 MHz). The second is a 4-cycle (about 244 ns) active-low local frame pulse that straddles the boundary. Every detected pulse realigns the counter. Between pulses, and after pulses stop, the counter keeps free-running.

Two flags report the health of the input. A sticky flag records a pulse whose low width misses the nominal width for the mode. A loss-of-frame flag rises when no pulse has arrived for slightly longer than a frame.

Top module: `frame_pulse_aligner`

## Requirements
- R1: The frame boundary strobe is high for exactly one cycle. That cycle follows the second master-clock rising edge counted from the first edge that samples the input pulse low, and a falling edge of the pulse is needed before another strobe.
- R2: The nominal low width in master cycles is 1 for mode code 0, 2 for code 1, and 4 for codes 2 and 3.
- R3: A low width that differs from the nominal width by more than one cycle sets the width error flag. The flag rises two edges after the pulse returns high and stays set until reset.
- R4: A pulse whose low width lies within one cycle of the nominal width leaves the width error flag clear.
- R5: The local clock output is high in the strobe cycle and the cycle after it, then low for two cycles, repeating with a period of four master cycles.
- R6: The local frame pulse output is low for four cycles: the two cycles before a boundary and the strobe cycle plus the one after it. The frame is 2048 master cycles long.
- R7: Without input pulses, the frame-phase counter keeps running and repeats the local outputs every 2048 cycles. When a pulse arrives, the phase restarts at the strobe cycle.
- R8: The loss-of-frame flag goes high in the cycle that lies 2049 cycles after the last strobe cycle, when no new pulse has arrived by then. It is low in every strobe cycle.
- R9: While reset is asserted, the outputs hold these values: strobe 0, local clock 0, local frame pulse 1, width error 0 and loss-of-frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Frame pulse convention: 0 single-cycle, 1 two-cycle, 2 or 3 four-cycle |
| fp_n | input | 1 | Incoming active-low 8 kHz frame pulse |
| frame_strobe | output | 1 | One-cycle frame boundary strobe |
| lclk_out | output | 1 | Local clock, master clock divided by four |
| lfp_n_out | output | 1 | Local active-low frame pulse, four cycles wide |
| width_err | output | 1 | Sticky flag for an out-of-tolerance pulse width |
| lof | output | 1 | Loss-of-frame flag |

## Verification
The assertions assume that the frame pulse is synchronous to the master clock and that the mode is held steady while a pulse is low. The bench therefore changes the pulse only on falling clock edges and sets the mode only while the block is in reset. The checks also assume that the frame phase advances by one each cycle unless a pulse realigns it. The bench keeps to this by spacing pulses at the nominal 2048-cycle frame, apart from one deliberate gap that is long enough to raise loss-of-frame.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic [1:0] {
    FPM_SINGLE   = 2'd0,
    FPM_DOUBLE   = 2'd1,
    FPM_QUAD     = 2'd2,
    FPM_QUAD_ALT = 2'd3
  } fp_mode_e;

  // Expected low width of the incoming pulse, in master cycles.
  function automatic int unsigned nominal_low(input logic [1:0] mode);
    case (fp_mode_e'(mode))
      FPM_SINGLE: return 1;
      FPM_DOUBLE: return 2;
      default:    return 4;
    endcase
  endfunction

  // True when a measured width falls outside nominal +/- tol.
  function automatic logic width_bad(input int unsigned width,
                                     input int unsigned nom,
                                     input int unsigned tol);
    return (width > nom + tol) || (width + tol < nom);
  endfunction

  // Local clock level for a given frame phase (master / 4).
  function automatic logic lclk_level(input int unsigned phase);
    return (phase % 4) < 2;
  endfunction

  // Local frame pulse level: low for two cycles each side of the boundary.
  function automatic logic lfp_level(input int unsigned phase,
                                     input int unsigned frame_len);
    return !((phase < 2) || (phase >= frame_len - 2));
  endfunction

endpackage

// File: rtl/fpa_edge_sampler.sv
module fpa_edge_sampler #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_n,
  output logic             fall_evt,
  output logic             rise_evt,
  output logic [CNT_W-1:0] low_len
);

  localparam logic [CNT_W-1:0] LEN_MAX = {CNT_W{1'b1}};

  logic samp_q;
  logic samp_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      samp_d <= 1'b1;
    end else begin
      samp_q <= fp_n;
      samp_d <= samp_q;
    end
  end

  assign fall_evt = samp_d & ~samp_q;
  assign rise_evt = ~samp_d & samp_q;

  // Counts the cycles the registered sample stays low; saturates.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len <= '0;
    end else if (fall_evt) begin
      low_len <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (!samp_q && low_len != LEN_MAX) begin
      low_len <= low_len + 1'b1;
    end
  end

endmodule

// File: rtl/fpa_width_monitor.sv
module fpa_width_monitor
  import fpa_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int WIDTH_TOL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             rise_evt,
  input  logic [CNT_W-1:0] low_len,
  output logic             bad_evt,
  output logic             width_err
);

  int unsigned nom;
  int unsigned measured;

  always_comb begin
    nom      = nominal_low(mode);
    measured = int'(low_len);
    bad_evt  = width_bad(measured, nom, WIDTH_TOL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_err <= 1'b0;
    end else if (rise_evt && bad_evt) begin
      width_err <= 1'b1;
    end
  end

endmodule

// File: rtl/fpa_timebase.sv
module fpa_timebase
  import fpa_pkg::*;
#(
  parameter int FRAME_LEN = 2048,
  parameter int PH_W      = $clog2(FRAME_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fall_evt,
  output logic [PH_W-1:0] phase,
  output logic            strobe,
  output logic            lclk,
  output logic            lfp_n
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_LEN - 1);
  localparam logic [PH_W-1:0] PH_RST  = PH_W'(2);

  logic [PH_W-1:0] phase_nxt;

  always_comb begin
    if (fall_evt)
      phase_nxt = '0;
    else if (phase == PH_LAST)
      phase_nxt = '0;
    else
      phase_nxt = phase + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_RST;
      strobe <= 1'b0;
      lclk   <= 1'b0;
      lfp_n  <= 1'b1;
    end else begin
      phase  <= phase_nxt;
      strobe <= fall_evt;
      lclk   <= lclk_level(int'(phase_nxt));
      lfp_n  <= lfp_level(int'(phase_nxt), FRAME_LEN);
    end
  end

endmodule

// File: rtl/fpa_lof_watch.sv
module fpa_lof_watch #(
  parameter int LOF_LIMIT = 2049,
  parameter int GAP_W     = $clog2(LOF_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_evt,
  output logic [GAP_W-1:0] gap,
  output logic             lof
);

  localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(LOF_LIMIT);

  logic [GAP_W-1:0] gap_nxt;

  always_comb begin
    if (fall_evt)
      gap_nxt = '0;
    else if (gap == GAP_TOP)
      gap_nxt = gap;
    else
      gap_nxt = gap + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
      lof <= 1'b0;
    end else begin
      gap <= gap_nxt;
      lof <= (gap_nxt == GAP_TOP);
    end
  end

endmodule

// File: rtl/frame_pulse_aligner.sv
module frame_pulse_aligner #(
  parameter int FRAME_LEN = 2048,
  parameter int LOF_LIMIT = 2049,
  parameter int WIDTH_TOL = 1,
  parameter int CNT_W     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       fp_n,
  output logic       frame_strobe,
  output logic       lclk_out,
  output logic       lfp_n_out,
  output logic       width_err,
  output logic       lof
);

  localparam int PH_W  = $clog2(FRAME_LEN);
  localparam int GAP_W = $clog2(LOF_LIMIT + 1);

  // Internal events, named for the checker.
  logic             fall_evt;
  logic             rise_evt;
  logic [CNT_W-1:0] low_len;
  logic             bad_evt;
  logic [PH_W-1:0]  phase;
  logic [GAP_W-1:0] gap;

  fpa_edge_sampler #(.CNT_W(CNT_W)) u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .fp_n     (fp_n),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt),
    .low_len  (low_len)
  );

  fpa_width_monitor #(.CNT_W(CNT_W), .WIDTH_TOL(WIDTH_TOL)) u_wmon (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .rise_evt  (rise_evt),
    .low_len   (low_len),
    .bad_evt   (bad_evt),
    .width_err (width_err)
  );

  fpa_timebase #(.FRAME_LEN(FRAME_LEN), .PH_W(PH_W)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_evt (fall_evt),
    .phase    (phase),
    .strobe   (frame_strobe),
    .lclk     (lclk_out),
    .lfp_n    (lfp_n_out)
  );

  fpa_lof_watch #(.LOF_LIMIT(LOF_LIMIT), .GAP_W(GAP_W)) u_lof (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall_evt (fall_evt),
    .gap      (gap),
    .lof      (lof)
  );

endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
  parameter int FRAME_LEN = 2048,
  parameter int LOF_LIMIT = 2049,
  parameter int PH_W      = 11,
  parameter int GAP_W     = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fall_evt,
  input logic             rise_evt,
  input logic             bad_evt,
  input logic [PH_W-1:0]  phase,
  input logic [GAP_W-1:0] gap,
  input logic             frame_strobe,
  input logic             lclk_out,
  input logic             lfp_n_out,
  input logic             width_err,
  input logic             lof
);

  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe);

  a_r1_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> frame_strobe);

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    width_err |=> width_err);

  a_r3_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(width_err) |-> $past(rise_evt && bad_evt));

  a_r5_clk_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> (lclk_out && !lfp_n_out));

  a_r7_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_evt && phase != PH_W'(FRAME_LEN - 1)) |=> (phase == $past(phase) + 1'b1));

  a_r8_lof_clear: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> !lof);

  a_r8_lof_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> (gap == GAP_W'(LOF_LIMIT)));

endmodule

bind frame_pulse_aligner fpa_checker #(
  .FRAME_LEN (FRAME_LEN),
  .LOF_LIMIT (LOF_LIMIT),
  .PH_W      (PH_W),
  .GAP_W     (GAP_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fall_evt     (fall_evt),
  .rise_evt     (rise_evt),
  .bad_evt      (bad_evt),
  .phase        (phase),
  .gap          (gap),
  .frame_strobe (frame_strobe),
  .lclk_out     (lclk_out),
  .lfp_n_out    (lfp_n_out),
  .width_err    (width_err),
  .lof          (lof)
);

// File: tb/frame_pulse_aligner_test.sv
`timescale 1ns/1ps
module frame_pulse_aligner_test;

  localparam realtime CLK_PERIOD = 61.0;
  localparam int FRAME = 2048;
  localparam int LIMIT = 2049;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       fp_n = 1'b1;
  logic       frame_strobe, lclk_out, lfp_n_out, width_err, lof;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  frame_pulse_aligner uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fp_n(fp_n),
    .frame_strobe(frame_strobe), .lclk_out(lclk_out), .lfp_n_out(lfp_n_out),
    .width_err(width_err), .lof(lof)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic int exp_width(input int m);
    if (m == 0) return 1;
    if (m == 1) return 2;
    return 4;
  endfunction

  // Apply reset with a mode, checking the held outputs (R9).
  task automatic do_reset(input int m);
    @(negedge clk);
    rst_n = 1'b0;
    fp_n  = 1'b1;
    mode  = 2'(m);
    repeat (2) @(negedge clk);
    check(frame_strobe == 0, "R9 strobe", frame_strobe, 0);
    check(lclk_out == 0,     "R9 lclk",   lclk_out, 0);
    check(lfp_n_out == 1,    "R9 lfp_n",  lfp_n_out, 1);
    check(width_err == 0,    "R9 err",    width_err, 0);
    check(lof == 0,          "R9 lof",    lof, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // One pulse of w cycles; checks R1, R5, R6 near the boundary and R3/R4 after.
  task automatic sweep_one(input int m, input int w);
    int  nom;
    bit  bad;
    int  p;
    string tag;
    do_reset(m);
    nom = exp_width(m);
    bad = (w - nom > 1) || (nom - w > 1);
    fp_n = 1'b0;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      check(frame_strobe == (j == 2), "R1 strobe timing", frame_strobe, int'(j == 2));
      if (j >= 2) begin
        p = j - 2;
        check(lclk_out == ((p % 4) < 2), "R5 lclk phase", lclk_out, int'((p % 4) < 2));
        check(lfp_n_out == !(p < 2), "R6 lfp_n around boundary", lfp_n_out, int'(!(p < 2)));
      end
      if (j == w) fp_n = 1'b1;
    end
    tag = bad ? "R3 width error set (R2 nominal)" : "R4 width within tolerance (R2 nominal)";
    check(width_err == bad, tag, width_err, int'(bad));
    repeat (3) @(negedge clk);
    check(width_err == bad, "R3 error sticky", width_err, int'(bad));
  endtask

  // Periodic frames, then a gap, then a late pulse: R1, R5, R6, R7, R8.
  task automatic long_run();
    int last_s;
    int p;
    int g;
    bit es;
    do_reset(1);
    fp_n   = 1'b0;
    last_s = 2;
    for (int j = 1; j <= 6210; j++) begin
      @(negedge clk);
      es = (j == 2) || (j == 2050) || (j == 6202);
      if (es) last_s = j;
      if (j >= 2) begin
        p = (j - last_s) % FRAME;
        g = j - last_s;
        if (frame_strobe != es)
          check(0, "R1 strobe position", frame_strobe, int'(es));
        if (lclk_out != ((p % 4) < 2))
          check(0, "R5 lclk", lclk_out, int'((p % 4) < 2));
        if (lfp_n_out != !(p < 2 || p >= FRAME - 2))
          check(0, "R7 free-running lfp_n", lfp_n_out, int'(!(p < 2 || p >= FRAME - 2)));
        if (lof != (g >= LIMIT))
          check(0, "R8 lof", lof, int'(g >= LIMIT));
        if (es) check(lof == 0, "R8 lof low at strobe", lof, 0);
        if (p == FRAME - 2) check(lfp_n_out == 0, "R6 lfp_n before boundary", lfp_n_out, 0);
        if (g == LIMIT - 1) check(lof == 0, "R8 lof not yet", lof, 0);
        if (g == LIMIT)     check(lof == 1, "R8 lof raised", lof, 1);
        if (j == 4000)      check(lclk_out == ((p % 4) < 2), "R7 clock keeps running", lclk_out, int'((p % 4) < 2));
      end
      if (j == 2 || j == 2050 || j == 6202) fp_n = 1'b1;
      if (j == 2048 || j == 6200) fp_n = 1'b0;
    end
    check(width_err == 0, "R4 two-cycle pulses in mode 1", width_err, 0);
  endtask

  initial begin
    for (int m = 0; m < 4; m++)
      for (int w = 1; w <= 6; w++)
        sweep_one(m, w);
    long_run();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

endmodule